// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Selectable Read Path

This block is a synchronous static RAM with one shared data port. The data port is modelled as the two directions of a single pad (`wdata` in, `rdata` out with `rdata_en` as the pad's driver enable). Chip select, write enable and address are sampled on the rising clock edge. A write is a late write: its data arrives on the edge that follows the command. The address and data then wait in a one-entry write buffer, and the array is updated from that buffer when the next write's data is captured. A read that hits the buffered address is served from the buffer, so the caller always sees the newest value.

Two static mode pins choose the read path. The first option registers the data for one more edge. The second passes it through a latch that is open while the clock is high. The third drives it straight from the array during the cycle after the command. In the latch and flow-through paths, a write command leaves the driver off in the following cycle, so read, write and read can be issued back to back. Output enable and sleep act without the clock. Sleep silences the outputs, makes the block ignore commands and keeps the stored contents. The organisation is set by `AW` and `DW`. For example, `AW`=17 with `DW`=36 gives 131072 words of 36 bits, and `AW`=18 with `DW`=18 gives 262144 words of 18 bits. The defaults are kept small.

Top module: `lwsram`

## Requirements
- R1: A command is taken only on a rising edge where `sel`=1. With `sel`=0, `wr_en`, `addr` and `wdata` change neither stored data nor the output.
- R2: For a write command sampled on edge N, the data is taken from `wdata` on edge N+1.
- R3: A completed write can be read back at any later time, including after its buffer entry has moved to the array because of a following write.
- R4: A read of the address held in the write buffer returns the buffered data. This includes a read issued on the edge where that data is captured.
- R5: With `mode_sel`=00 (register-register), the data for a read sampled on edge N is driven with `rdata_en`=1 between edges N+1 and N+2.
- R6: With `mode_sel`=01 (register-latch), the data for a read sampled on edge N passes an output latch that is open while `clk` is high. It is valid, and held through the low phase, between edges N and N+1.
- R7: With `mode_sel`=10 (flow-through), the data for a read sampled on edge N is driven between edges N and N+1, taken directly from the array or buffer lookup.
- R8: `mode_sel`=11 behaves exactly like 00.
- R9: With `mode_sel`=01 or 10, a write command sampled on edge N leaves `rdata_en`=0 between edges N and N+1.
- R10: `oe_n`=1 forces `rdata_en`=0 at once, without waiting for a clock edge. Whenever `rdata_en`=0, `rdata` is all zeros.
- R11: While `sleep`=1, `rdata_en`=0, commands are ignored, and a late-write data capture due on that edge is dropped. Array contents survive the sleep.
- R12: An active-low `rst_n` clears any pending read, write or buffered entry and turns the output off. The array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Static read-path select: 00/11 registered, 01 latched, 10 flow-through |
| sel | input | 1 | Chip select for the command on this edge |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| addr | input | AW | Word address |
| wdata | input | DW | Write data (input side of the shared data pad) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous power-down request |
| rdata | output | DW | Read data (output side of the shared data pad), zero when not driven |
| rdata_en | output | 1 | Pad driver enable for `rdata` |

## Verification
If the write buffer is wrong (stale address, missed capture, or a commit to the array that never happens), the first read of an affected address returns the wrong word. In flow-through and latch modes this shows in the cycle after the read is sampled, and in registered mode one cycle later. A wrong command stage shows up as `rdata_en` asserting in the wrong cycle, in particular right after a write. A leak through sleep only appears once sleep is released and the word is read again. The reference model follows each of these paths every cycle in all four mode encodings.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef enum logic [1:0] {
    RD_REGREG = 2'b00,
    RD_LATCH  = 2'b01,
    RD_FLOW   = 2'b10,
    RD_RSVD   = 2'b11
  } rd_mode_e;

endpackage

// File: rtl/lwsram_store.sv
// Storage array plus one-entry late-write buffer with read bypass.
module lwsram_store #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,       // late-write data capture this edge
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic [AW-1:0] look_addr,
  output logic [DW-1:0] look_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          buf_vld_q, buf_vld_nxt;
  logic [AW-1:0] buf_addr_q;
  logic [DW-1:0] buf_data_q;
  logic          commit;

  assign commit = cap & buf_vld_q;

  always_comb begin
    buf_vld_nxt = buf_vld_q | cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_vld_q <= 1'b0;
    else        buf_vld_q <= buf_vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      buf_addr_q <= cap_addr;
      buf_data_q <= cap_data;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[buf_addr_q] <= buf_data_q;
  end

  always_comb begin
    if (buf_vld_q && (buf_addr_q == look_addr)) look_data = buf_data_q;
    else                                        look_data = mem[look_addr];
  end

endmodule

// File: rtl/lwsram_outstage.sv
// Three read paths, selected by static pins, plus asynchronous gating.
module lwsram_outstage
  import lwsram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          rd,
  input  logic [DW-1:0] lk_data,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] q,
  output logic          q_en
);
  logic          rr_v_q, rr_v_nxt;
  logic [DW-1:0] rr_d_q;
  logic          lt_v;
  logic [DW-1:0] lt_d;
  logic          sel_v;
  logic [DW-1:0] sel_d;

  always_comb begin
    rr_v_nxt = rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_v_q <= 1'b0;
    else        rr_v_q <= rr_v_nxt;
  end

  always_ff @(posedge clk) begin
    if (rd) rr_d_q <= lk_data;
  end

  always_latch begin
    if (!rst_n)   lt_v <= 1'b0;
    else if (clk) lt_v <= rd;
  end

  always_latch begin
    if (clk) lt_d <= lk_data;
  end

  always_comb begin
    case (rd_mode_e'(mode_sel))
      RD_LATCH: begin sel_v = lt_v;   sel_d = lt_d;   end
      RD_FLOW:  begin sel_v = rd;     sel_d = lk_data; end
      default:  begin sel_v = rr_v_q; sel_d = rr_d_q; end
    endcase
  end

  assign q_en = sel_v & ~oe_n & ~sleep;
  assign q    = q_en ? sel_d : '0;

endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          sel,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] rdata,
  output logic          rdata_en
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic                  take;
  logic                  rd_q, rd_nxt;
  logic                  wr_q, wr_nxt;
  logic [AW-1:0]         addr_q;
  logic                  cap;
  logic [DW-1:0]         lk_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  always_comb begin
    take   = sel & ~sleep;
    rd_nxt = take & ~wr_en;
    wr_nxt = take & wr_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_nxt;
      wr_q <= wr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (take) addr_q <= addr;
  end

  assign cap = wr_q & ~sleep;

  lwsram_store #(.AW(AW), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cap       (cap),
    .cap_addr  (addr_q),
    .cap_data  (wdata),
    .look_addr (addr_q),
    .look_data (lk_data)
  );

  lwsram_outstage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mode_sel (mode_sel),
    .rd       (rd_q),
    .lk_data  (lk_data),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .q        (rdata),
    .q_en     (rdata_en)
  );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_sel,
  input logic          sel,
  input logic          wr_en,
  input logic          oe_n,
  input logic          sleep,
  input logic [DW-1:0] rdata,
  input logic          rdata_en
);

  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 2'b01) || (mode_sel == 2'b10)) && $past(sel && wr_en && !sleep)
    |-> !rdata_en); // R9

  AST_REGREG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 2'b00) || (mode_sel == 2'b11)) && rdata_en
    |-> $past(sel && !wr_en && !sleep, 2)); // R5

  AST_FLOW_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) && rdata_en |-> $past(sel && !wr_en && !sleep)); // R7

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_en); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> (rdata == '0)); // R10

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_en); // R11

endmodule

bind lwsram lwsram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .sel      (sel),
  .wr_en    (wr_en),
  .oe_n     (oe_n),
  .sleep    (sleep),
  .rdata    (rdata),
  .rdata_en (rdata_en)
);

// File: tb/lwsram_test.sv
module lwsram_test;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          sel, wr_en, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_en;

  int    checks = 0;
  int    fails  = 0;
  bit    running = 0;
  bit    done = 0;
  string tag = "R12";

  always #(CLK_NS/2) clk = ~clk;

  lwsram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  // Behavioural reference model
  logic [DW-1:0] mmem [int];
  bit            pv;
  int            pa;
  logic [DW-1:0] pd;
  bit            m_rd, m_wr;
  int            m_addr;
  bit            rr_v;
  logic [DW-1:0] rr_d;

  function automatic logic [DW-1:0] look(int a);
    if (pv && pa == a) return pd;
    if (mmem.exists(a)) return mmem[a];
    return 'x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv = 0; m_rd = 0; m_wr = 0; rr_v = 0;
    end else begin
      rr_v = m_rd;
      if (m_rd) rr_d = look(m_addr);
      if (m_wr && !sleep) begin
        if (pv) mmem[pa] = pd;
        pv = 1; pa = m_addr; pd = wdata;
      end
      m_rd = sel && !wr_en && !sleep;
      m_wr = sel && wr_en && !sleep;
      if (sel && !sleep) m_addr = int'(addr);
    end
  end

  always @(negedge clk) begin
    if (running) begin
      bit            v, en;
      logic [DW-1:0] d, q;
      if (mode_sel == 2'b00 || mode_sel == 2'b11) begin v = rr_v; d = rr_d; end
      else begin v = m_rd; d = look(m_addr); end
      en = v && !oe_n && !sleep;
      q  = en ? d : '0;
      checks++;
      if (rdata_en !== en || rdata !== q) begin
        fails++;
        $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
                 tag, rdata_en, rdata, en, q);
      end
    end
  end

  task automatic step(bit s, bit w, int a, logic [DW-1:0] d);
    @(negedge clk); #1;
    sel = s; wr_en = w; addr = a[AW-1:0]; wdata = d;
  endtask

  function automatic logic [DW-1:0] pat(int md, int k);
    return DW'(64'h5_A5C3_0000 + md * 4096 + k * 37);
  endfunction

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R12: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; sel = 0; wr_en = 0; addr = '0; wdata = '0;
    oe_n = 0; sleep = 0;
    running = 1;
    tag = "R12";
    repeat (3) step(0, 0, 0, '0);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, '0);

    for (int md = 0; md < 4; md++) begin
      int b;
      string mtag;
      b = md * 16;
      mtag = (md == 0) ? "R5" : (md == 1) ? "R6" : (md == 2) ? "R7" : "R8";
      mode_sel = md[1:0];
      repeat (3) step(0, 0, 0, '0);
      tag = "R2";
      step(1, 1, b + 1, '0);
      step(1, 1, b + 2, pat(md, 1));
      tag = "R3";
      step(1, 0, b + 1, pat(md, 2));
      tag = "R4";
      step(1, 0, b + 2, '0);
      tag = mtag;
      step(1, 0, b + 1, '0);
      step(0, 0, 0, '0);
      step(1, 0, b + 2, '0);
      tag = "R9";
      step(1, 1, b + 3, '0);
      step(1, 0, b + 3, pat(md, 3));
      step(1, 0, b + 1, '0);
      step(0, 0, 0, '0);
      tag = "R10";
      oe_n = 1;
      step(1, 0, b + 2, '0);
      step(1, 0, b + 3, '0);
      oe_n = 0;
      step(1, 0, b + 1, '0);
      step(0, 0, 0, '0);
      tag = "R1";
      step(0, 1, b + 1, pat(md, 9));
      step(0, 0, b + 2, pat(md, 10));
      step(1, 0, b + 1, '0);
      step(1, 0, b + 2, '0);
      tag = "R11";
      sleep = 1;
      step(1, 1, b + 1, '0);
      step(1, 0, b + 2, pat(md, 11));
      step(0, 0, 0, '0);
      sleep = 0;
      step(1, 1, b + 2, '0);
      sleep = 1;
      step(0, 0, 0, pat(md, 12));
      sleep = 0;
      step(1, 0, b + 1, '0);
      step(1, 0, b + 2, '0);
      step(1, 0, b + 3, '0);
      repeat (3) step(0, 0, 0, '0);
    end

    tag = "R12";
    mode_sel = 2'b00;
    step(1, 1, 128, '0);
    step(1, 1, 128, pat(5, 1));
    step(0, 0, 0, pat(5, 2));
    step(0, 0, 0, '0);
    rst_n = 0;
    step(0, 0, 0, '0);
    step(0, 0, 0, '0);
    rst_n = 1;
    repeat (4) step(0, 0, 0, '0);
    step(1, 0, 128, '0);
    repeat (4) step(0, 0, 0, '0);

    running = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule